// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits between a host-side request port and a low-level serial-flash command engine. A single request names an operation (program a byte range, erase a range, bulk read, or identify the device) together with a start address and a byte length. The sequencer turns that request into an ordered series of single flash commands. It issues each command to the engine with a one-cycle start pulse and waits for the engine's done pulse before it issues the next one.

Programs are cut so that no chunk crosses a 256-byte page. Each chunk is wrapped in a write-enable, a busy-poll loop on the status register, and a write-disable. Erases step through the range one 4 KB sector at a time. Long reads are split into 32 KB transfers. The identify operation decodes the device capacity from the third ID byte and guards against an engine that never answers.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `seq_done`, `cmd_start` and `seq_err` are 0 and `dev_size_mbit` is 0.
- R2: A program (`req_op`=0) of length L at address A is issued as page-program chunks. The first chunk has length min(L, 256 − A mod 256) at A. Each following chunk has length min(256, remaining) at the next address. No chunk crosses a 256-byte boundary.
- R3: Every program chunk issues commands in this order: opcode 0x06 (address 0, length 0); then opcode 0x02 with the chunk address and length; then opcode 0x05 (address 0, length 1), repeated while `cmd_rdata[0]` of the reply is 1; then opcode 0x04 (address 0, length 0).
- R4: A program request with length 0 completes with `seq_err`=1 and issues no command.
- R5: An erase (`req_op`=1) walks address a = A, A+4096, … while a < A+L. For each a it issues 0x06, then 0x20 at address a (length 0), then 0x05 until bit 0 of the reply is clear. No write-disable is issued. A zero length issues nothing and ends with `seq_err`=0.
- R6: A read (`req_op`=2) issues opcode 0x0B with length 32768 while more than 32768 bytes remain, advancing the address each time, then one final read of the remainder.
- R7: Identify (`req_op`=3) issues opcode 0x9F with length 3. If the reply `cmd_rdata` (manufacturer in bits 23:16, capacity byte in bits 7:0) is not all ones, `dev_size_mbit` becomes 1 << (bits 7:0 − 0x11) and `seq_err`=0. If it is all ones, `seq_err`=3 and `dev_size_mbit` is unchanged.
- R8: If no done arrives within 500 cycles of an identify command's start, the sequencer abandons the command and completes with `seq_err`=2.
- R9: Only one command is outstanding at a time: no `cmd_start` occurs between a start and its matching `cmd_done`.
- R10: `busy` is high from the cycle after a request is accepted until completion. `cmd_start` occurs only while busy. Requests presented while busy are ignored.
- R11: `seq_done` is a one-cycle pulse, with `seq_err` valid, in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 2 | 0 program, 1 erase, 2 read, 3 identify |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| seq_done | output | 1 | Completion pulse |
| seq_err | output | 2 | 0 ok, 1 zero length, 2 identify timeout, 3 blank ID |
| dev_size_mbit | output | SIZE_W | Decoded device size in megabits |
| cmd_start | output | 1 | Start pulse to command engine |
| cmd_opcode | output | 8 | Flash opcode for the command |
| cmd_addr | output | ADDR_W | Flash address (0 when unused) |
| cmd_len | output | LEN_W | Data byte count of the command |
| cmd_done | input | 1 | Command engine completion pulse |
| cmd_rdata | input | 24 | Reply data (status byte in bits 7:0, or ID bytes) |

## Verification
The hardest states to reach are those where the engine misbehaves or stalls. One is an identify command whose done pulse never arrives, so the 500-cycle abandonment path must run out in full. The other is a status register that reports busy several times in a row. The bench's engine model can be told to withhold done for the identify opcode, and to answer a set number of status reads with bit 0 set after each page program or sector erase. This drives the poll loop through several iterations and leads to a timeout whose completion time the bench measures.

// File: rtl/flash_seq_pkg.sv
// Shared opcodes, operation codes, error codes and FSM states for the
// flash sequencer. Assumes 8-bit serial-flash opcodes.
package flash_seq_pkg;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_SECT  = 8'h20;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_FREAD = 8'h0B;
    localparam logic [7:0] CMD_RDID  = 8'h9F;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_READ  = 2'd2,
        OP_IDENT = 2'd3
    } seq_op_e;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_ZERO_LEN   = 2'd1,
        ERR_ID_TIMEOUT = 2'd2,
        ERR_ID_BLANK   = 2'd3
    } seq_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_WREN,
        S_MAIN,
        S_POLL,
        S_WRDI,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/flash_chunk_calc.sv
// Combinational chunk planner. Given the operation, the current cursor,
// the bytes still to do and the erase end address, it returns the length
// of the next command, whether any work remains, and whether this chunk is
// the last one. Assumes LEN_W is wider than the page offset field.
module flash_chunk_calc
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int LEN_W        = 24,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int READ_CHUNK   = 32768
) (
    input  seq_op_e            op_i,
    input  logic [ADDR_W:0]    cursor_i,
    input  logic [LEN_W-1:0]   remain_i,
    input  logic [ADDR_W:0]    end_i,
    output logic [LEN_W-1:0]   chunk_o,
    output logic               work_o,
    output logic               last_o
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] head_room;
    logic [LEN_W-1:0] read_cap;

    // Bytes left before the next page boundary.
    always_comb head_room = LEN_W'(PAGE_BYTES) - LEN_W'(cursor_i[PAGE_W-1:0]);
    always_comb read_cap  = LEN_W'(READ_CHUNK);

    // Select chunk length and loop condition per operation.
    always_comb begin
        chunk_o = '0;
        work_o  = 1'b0;
        last_o  = 1'b1;
        unique case (op_i)
            OP_PROG: begin
                chunk_o = (remain_i < head_room) ? remain_i : head_room;
                work_o  = (remain_i != '0);
                last_o  = (remain_i <= head_room);
            end
            OP_ERASE: begin
                chunk_o = LEN_W'(SECTOR_BYTES);
                work_o  = (cursor_i < end_i);
                last_o  = 1'b0;
            end
            OP_READ: begin
                chunk_o = (remain_i > read_cap) ? read_cap : remain_i;
                work_o  = 1'b1;
                last_o  = (remain_i <= read_cap);
            end
            default: begin
                chunk_o = LEN_W'(3);
                work_o  = 1'b1;
                last_o  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/flash_id_decode.sv
// Decodes a 3-byte device ID. The capacity byte (bits 7:0) gives the size
// in megabits as 1 << (byte - 0x11). An all-ones ID marks a missing device.
module flash_id_decode #(
    parameter int SIZE_W = 32
) (
    input  logic [23:0]       id_i,
    output logic              blank_o,
    output logic [SIZE_W-1:0] size_o
);
    logic [7:0] shamt;

    // Blank detection and shift amount.
    always_comb begin
        blank_o = &id_i;
        shamt   = id_i[7:0] - 8'h11;
    end

    // Size from shift amount.
    always_comb size_o = SIZE_W'(1) << shamt;
endmodule

// File: rtl/flash_poll_timer.sv
// Counts cycles while a watched command is outstanding and flags expiry
// when LIMIT cycles pass without the done pulse. Assumes LIMIT >= 2.
module flash_poll_timer #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic hit_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Expiry when the last allowed cycle passes without done.
    always_comb expired_o = run_i && !hit_i && (cnt == CNT_W'(LIMIT - 1));

    // Cycle counter, cleared whenever nothing is being watched.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt <= '0;
        else if (!expired_o)  cnt <= cnt + 1'b1;
    end

    AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT)); // R8
    AST_TIMER_EXPIRES_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> !run_i || hit_i || (cnt == $past(cnt))); // R8
endmodule

// File: rtl/flash_seq.sv
// Flash program/erase sequencer. Accepts one request at a time and breaks
// it into serial-flash commands issued to a command engine through a
// start/done handshake with a single outstanding command. Assumes the
// engine answers every command except possibly an ID read.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int LEN_W         = 24,
    parameter int PAGE_BYTES    = 256,
    parameter int SECTOR_BYTES  = 4096,
    parameter int READ_CHUNK    = 32768,
    parameter int ID_POLL_LIMIT = 500,
    parameter int SIZE_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              seq_done,
    output logic [1:0]        seq_err,
    output logic [SIZE_W-1:0] dev_size_mbit,
    output logic              cmd_start,
    output logic [7:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_done,
    input  logic [23:0]       cmd_rdata
);
    localparam int CUR_W  = ADDR_W + 1;
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int SUM_W  = LEN_W + 1;

    seq_state_e        state;
    seq_op_e           op_q;
    seq_err_e          err_q;
    logic [CUR_W-1:0]  cursor;
    logic [CUR_W-1:0]  end_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  chunk_q;
    logic              last_q;
    logic              pending;
    logic              done_q;
    logic [SIZE_W-1:0] size_q;

    logic [LEN_W-1:0]  chunk_len;
    logic              has_work;
    logic              is_last;
    logic              id_blank;
    logic [SIZE_W-1:0] id_size;
    logic              tmr_run;
    logic              tmr_expired;

    logic              cmd_state;
    logic              step_done;
    logic [7:0]        nxt_opcode;
    logic [ADDR_W-1:0] nxt_addr;
    logic [LEN_W-1:0]  nxt_len;

    flash_chunk_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES), .READ_CHUNK(READ_CHUNK)
    ) u_calc (
        .op_i(op_q), .cursor_i(cursor), .remain_i(remain), .end_i(end_addr),
        .chunk_o(chunk_len), .work_o(has_work), .last_o(is_last)
    );

    flash_id_decode #(.SIZE_W(SIZE_W)) u_id (
        .id_i(cmd_rdata), .blank_o(id_blank), .size_o(id_size)
    );

    flash_poll_timer #(.LIMIT(ID_POLL_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run_i(tmr_run), .hit_i(cmd_done),
        .expired_o(tmr_expired)
    );

    // Watch only the outstanding ID command for the timeout.
    always_comb tmr_run = (state == S_MAIN) && (op_q == OP_IDENT) && pending;

    // Command that the current state would issue.
    always_comb begin
        cmd_state  = 1'b1;
        nxt_opcode = CMD_WREN;
        nxt_addr   = '0;
        nxt_len    = '0;
        unique case (state)
            S_WREN: nxt_opcode = CMD_WREN;
            S_WRDI: nxt_opcode = CMD_WRDI;
            S_POLL: begin
                nxt_opcode = CMD_RDSR;
                nxt_len    = LEN_W'(1);
            end
            S_MAIN: begin
                nxt_addr = cursor[ADDR_W-1:0];
                nxt_len  = chunk_q;
                unique case (op_q)
                    OP_PROG:  nxt_opcode = CMD_PROG;
                    OP_ERASE: begin
                        nxt_opcode = CMD_SECT;
                        nxt_len    = '0;
                    end
                    OP_READ:  nxt_opcode = CMD_FREAD;
                    default: begin
                        nxt_opcode = CMD_RDID;
                        nxt_addr   = '0;
                        nxt_len    = LEN_W'(3);
                    end
                endcase
            end
            default: cmd_state = 1'b0;
        endcase
    end

    // Handshake completion of the command in flight.
    always_comb step_done = cmd_state && pending && cmd_done;

    // Main sequencing: accept, plan, issue, advance, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_PROG;
            err_q      <= ERR_NONE;
            cursor     <= '0;
            end_addr   <= '0;
            remain     <= '0;
            chunk_q    <= '0;
            last_q     <= 1'b0;
            pending    <= 1'b0;
            done_q     <= 1'b0;
            size_q     <= '0;
            cmd_start  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
            cmd_len    <= '0;
        end else begin
            cmd_start <= 1'b0;
            done_q    <= 1'b0;
            if (cmd_state && !pending) begin
                cmd_start  <= 1'b1;
                pending    <= 1'b1;
                cmd_opcode <= nxt_opcode;
                cmd_addr   <= nxt_addr;
                cmd_len    <= nxt_len;
            end
            if (step_done) pending <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q     <= seq_op_e'(req_op);
                    cursor   <= {1'b0, req_addr};
                    end_addr <= {1'b0, req_addr} + CUR_W'(req_len);
                    remain   <= req_len;
                    if (seq_op_e'(req_op) == OP_PROG && req_len == '0) begin
                        err_q <= ERR_ZERO_LEN;
                        state <= S_FINISH;
                    end else begin
                        err_q <= ERR_NONE;
                        state <= S_PLAN;
                    end
                end
                S_PLAN: begin
                    chunk_q <= chunk_len;
                    last_q  <= is_last;
                    if (!has_work)                                  state <= S_FINISH;
                    else if (op_q == OP_PROG || op_q == OP_ERASE)   state <= S_WREN;
                    else                                            state <= S_MAIN;
                end
                S_WREN: if (step_done) state <= S_MAIN;
                S_MAIN: begin
                    if (tmr_expired) begin
                        pending <= 1'b0;
                        err_q   <= ERR_ID_TIMEOUT;
                        state   <= S_FINISH;
                    end else if (step_done) begin
                        unique case (op_q)
                            OP_PROG: begin
                                cursor <= cursor + CUR_W'(chunk_q);
                                remain <= remain - chunk_q;
                                state  <= S_POLL;
                            end
                            OP_ERASE: state <= S_POLL;
                            OP_READ: begin
                                cursor <= cursor + CUR_W'(chunk_q);
                                remain <= remain - chunk_q;
                                state  <= last_q ? S_FINISH : S_PLAN;
                            end
                            default: begin
                                if (id_blank) err_q  <= ERR_ID_BLANK;
                                else          size_q <= id_size;
                                state <= S_FINISH;
                            end
                        endcase
                    end
                end
                S_POLL: if (step_done && !cmd_rdata[0]) begin
                    if (op_q == OP_PROG) state <= S_WRDI;
                    else begin
                        cursor <= cursor + CUR_W'(SECTOR_BYTES);
                        state  <= S_PLAN;
                    end
                end
                S_WRDI: if (step_done) state <= S_PLAN;
                default: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        busy          = (state != S_IDLE);
        seq_done      = done_q;
        seq_err       = err_q;
        dev_size_mbit = size_q;
    end

    AST_NO_SECOND_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !cmd_done && !cmd_start) |=> !cmd_start); // R9
    AST_PAGE_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == CMD_PROG) |->
        (cmd_len != '0) &&
        (SUM_W'(cmd_addr[PAGE_W-1:0]) + SUM_W'(cmd_len) <= SUM_W'(PAGE_BYTES))); // R2
    AST_READ_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == CMD_FREAD) |-> cmd_len <= LEN_W'(READ_CHUNK)); // R6
    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> busy); // R10
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!busy && $past(busy))); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R11
endmodule

// File: tb/flash_seq_test.sv
// Directed bench: one task per scenario, each checking its own results.
module flash_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic        busy, seq_done, cmd_start;
    logic [1:0]  seq_err;
    logic [31:0] dev_size_mbit;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr, cmd_len;
    logic        cmd_done = 1'b0;
    logic [23:0] cmd_rdata = '0;

    flash_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .seq_done(seq_done),
        .seq_err(seq_err), .dev_size_mbit(dev_size_mbit), .cmd_start(cmd_start),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Engine model configuration and command log.
    int          poll_cfg = 0;
    int          poll_left = 0;
    bit          id_silent = 0;
    logic [23:0] id_value = '0;
    bit          outstanding = 0;
    int          overlap = 0;
    int          lat = 0;
    int          n_log = 0;
    logic [7:0]  log_op [0:63];
    logic [23:0] log_addr [0:63];
    logic [23:0] log_len [0:63];
    int          n_exp = 0;
    logic [7:0]  exp_op [0:63];
    logic [23:0] exp_addr [0:63];
    logic [23:0] exp_len [0:63];
    logic [1:0]  last_err;
    int          last_cycles;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Command engine model: logs starts, answers after two cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_done) cmd_done = 1'b0;
            else if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    cmd_done = 1'b1;
                    outstanding = 0;
                end
            end
            if (cmd_start) begin
                if (outstanding) overlap++;
                outstanding = 1;
                if (n_log < 64) begin
                    log_op[n_log] = cmd_opcode;
                    log_addr[n_log] = cmd_addr;
                    log_len[n_log] = cmd_len;
                end
                n_log++;
                cmd_rdata = '0;
                if (cmd_opcode == 8'h02 || cmd_opcode == 8'h20) poll_left = poll_cfg;
                if (cmd_opcode == 8'h05) begin
                    cmd_rdata = (poll_left > 0) ? 24'h1 : 24'h0;
                    if (poll_left > 0) poll_left--;
                end
                if (cmd_opcode == 8'h9F) cmd_rdata = id_value;
                if (!(id_silent && cmd_opcode == 8'h9F)) lat = 2;
            end
        end
    end

    task automatic push(input logic [7:0] o, input logic [23:0] a, input logic [23:0] l);
        exp_op[n_exp] = o; exp_addr[n_exp] = a; exp_len[n_exp] = l;
        n_exp++;
    endtask

    task automatic compare_log(input string tag);
        chk(n_log == n_exp, {tag, " command count"}, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk(log_op[i] == exp_op[i] && log_addr[i] == exp_addr[i] && log_len[i] == exp_len[i],
                {tag, " command"}, {log_op[i], log_addr[i]}, {exp_op[i], exp_addr[i]});
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [23:0] a, input logic [23:0] l);
        n_log = 0; n_exp = 0;
        @(negedge clk);
        req_op = op; req_addr = a; req_len = l; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        last_cycles = 1;
        while (!seq_done && last_cycles < 5000) begin
            @(negedge clk);
            last_cycles++;
        end
        last_err = seq_err;
        chk(seq_done && !busy, "R11 done with busy low", busy, 0);
        @(negedge clk);
        chk(!seq_done, "R11 done one cycle", seq_done, 0);
    endtask

    task automatic exp_prog(input int a, input int l, input int polls);
        int c;
        while (l > 0) begin
            c = 256 - (a % 256);
            if (c > l) c = l;
            push(8'h06, 0, 0);
            push(8'h02, a[23:0], c[23:0]);
            for (int k = 0; k <= polls; k++) push(8'h05, 0, 1);
            push(8'h04, 0, 0);
            a += c; l -= c;
        end
    endtask

    task automatic t_reset;
        chk(!busy && !seq_done && !cmd_start, "R1 reset controls", {busy, seq_done, cmd_start}, 0);
        chk(seq_err == 0 && dev_size_mbit == 0, "R1 reset values", dev_size_mbit, 0);
    endtask

    task automatic t_program;
        poll_cfg = 2;
        run_req(2'd0, 24'h0001F0, 24'd600);
        exp_prog(32'h1F0, 600, 2);
        compare_log("R2 R3 unaligned program");
        chk(last_err == 0, "R3 program err", last_err, 0);
        poll_cfg = 0;
        run_req(2'd0, 24'h000010, 24'd5);
        exp_prog(32'h10, 5, 0);
        compare_log("R2 short head");
        run_req(2'd0, 24'h000100, 24'd512);
        exp_prog(32'h100, 512, 0);
        compare_log("R2 aligned pages");
    endtask

    task automatic t_zero_prog;
        run_req(2'd0, 24'h000040, 24'd0);
        chk(last_err == 2'd1, "R4 zero length error", last_err, 1);
        chk(n_log == 0, "R4 no commands", n_log, 0);
    endtask

    task automatic t_erase;
        poll_cfg = 1;
        run_req(2'd1, 24'h001800, 24'h002001);
        for (int a = 32'h1800; a < 32'h3801; a += 4096) begin
            push(8'h06, 0, 0);
            push(8'h20, a[23:0], 0);
            push(8'h05, 0, 1);
            push(8'h05, 0, 1);
        end
        compare_log("R5 erase steps");
        chk(last_err == 0, "R5 erase err", last_err, 0);
        run_req(2'd1, 24'h004000, 24'd0);
        chk(n_log == 0 && last_err == 0, "R5 zero erase", n_log, 0);
        poll_cfg = 0;
    endtask

    task automatic t_read;
        run_req(2'd2, 24'h010000, 24'd70000);
        push(8'h0B, 24'h010000, 24'd32768);
        push(8'h0B, 24'h018000, 24'd32768);
        push(8'h0B, 24'h020000, 24'd4464);
        compare_log("R6 read split");
        run_req(2'd2, 24'h000000, 24'd65536);
        push(8'h0B, 24'h000000, 24'd32768);
        push(8'h0B, 24'h008000, 24'd32768);
        compare_log("R6 exact multiple");
    endtask

    task automatic t_ident;
        id_value = 24'hC22014;
        run_req(2'd3, 24'h0, 24'h0);
        push(8'h9F, 0, 3);
        compare_log("R7 id command");
        chk(last_err == 0 && dev_size_mbit == 32'd8, "R7 size decode", dev_size_mbit, 8);
        id_value = 24'hFFFFFF;
        run_req(2'd3, 24'h0, 24'h0);
        chk(last_err == 2'd3, "R7 blank id error", last_err, 3);
        chk(dev_size_mbit == 32'd8, "R7 size kept", dev_size_mbit, 8);
    endtask

    task automatic t_id_timeout;
        id_silent = 1;
        run_req(2'd3, 24'h0, 24'h0);
        chk(last_err == 2'd2, "R8 timeout error", last_err, 2);
        chk(last_cycles >= 500 && last_cycles <= 520, "R8 timeout window", last_cycles, 504);
        chk(n_log == 1, "R8 single id command", n_log, 1);
        id_silent = 0;
        outstanding = 0;
    endtask

    task automatic t_busy_ignore;
        n_log = 0;
        @(negedge clk);
        req_op = 2'd2; req_addr = 24'h000200; req_len = 24'd100; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R10 busy after accept", busy, 1);
        @(negedge clk);
        req_op = 2'd0; req_addr = 24'h000000; req_len = 24'd10; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 50 && !seq_done; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(!busy, "R10 idle after ignored request", busy, 0);
        chk(n_log == 1 && log_op[0] == 8'h0B && log_len[0] == 24'd100,
            "R10 only first request ran", n_log, 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_zero_prog();
        t_erase();
        t_read();
        t_ident();
        t_id_timeout();
        t_busy_ignore();
        chk(overlap == 0, "R9 one outstanding command", overlap, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule